// File: doc/BRIEF.md
# Flash-Backed DRAM Module Save/Restore Controller

This block is the module-side sequencer of a DRAM module whose contents can be preserved in flash across a power failure. In normal operation the host owns the DRAM as it would on any registered memory module. Once the backup energy store reports charged and the module's health checks are good, software may arm the module through a small register port. A save request then arrives as a falling edge on an active-low, open-drain save line. The controller cuts the DRAM off from the host and asks a power switch to move the module onto stored energy. Only after that switch acknowledges does it start a copy engine that moves DRAM to flash.

When the copy finishes, the controller pulls the shared save line low for a fixed number of cycles to tell the host the save is over. It then releases the stored energy and asks for every rail and clock to be shut down. When main power returns, it has the copy engine restore DRAM from flash, provided a valid image exists. It then hands the DRAM back to the host. Problems are kept in sticky status flags that software clears by writing ones. Any error flag pulls an active-low event output.

Top module: `nvm_backup_ctrl`

## Requirements
- R1: After reset the host owns the DRAM (host_iso low), the module is not armed, every status flag is 0, event_n is high, and no request output (pwr_req, cpy_start, save_n_oe, off_req) is active.
- R2: A write to address 0 sets the armed bit to reg_wdata bit 0 only while both health_ok and energy_ok are high; otherwise arming is refused. While in host mode, the armed bit drops in the cycle after either input goes low.
- R3: A falling edge on save_n_in passes a two-stage synchronizer, and is acted on two clock edges after it is sampled. If the module is armed, the edge raises host_iso and pwr_req and disarms the module. cpy_start with cpy_dir low follows only after pwr_ack has been seen.
- R4: When cpy_done arrives without cpy_fail, the valid-image flag is set. The module then reports and shuts down: save_n_oe first, then off_req high with pwr_req low.
- R5: In the shut-down state, a pulse on pwr_ret with a valid image held starts a restore (cpy_start with cpy_dir high). When the restore's cpy_done arrives, host_iso falls and the module is back in host mode and not armed.
- R6: save_n_oe (drive the save line low) is high for exactly HOLD_CYC consecutive cycles per save, and at no other time.
- R7: event_n is low exactly while at least one of the error flags (save error, restore error, unarmed-trigger error) is set.
- R8: Reads are combinational. Address 0 returns the armed bit in bit 0. Address 1 returns status: bit 0 armed, bit 1 save-in-progress, bit 2 valid image, bit 3 save error, bit 4 restore error, bit 5 unarmed-trigger error, bit 6 energy_ok, bit 7 health_ok. Address 2 returns the phase code: 0 host, 1 isolate, 2 copy, 3 report, 4 off, 5 restore. Address 3 returns 0.
- R9: A save edge in host mode while not armed leaves the phase and every output other than event_n unchanged, and sets the unarmed-trigger error flag.
- R10: If cpy_fail comes with cpy_done during a save, the save error flag is set and the valid-image flag stays 0. The report and shutdown still complete.
- R11: On pwr_ret with no valid image, or when a restore ends with cpy_fail, the restore error flag is set and the host regains the DRAM.
- R12: An accepted save sets save-in-progress and clears valid image. Status bits 1 to 5 stay set until a write to address 1 has a 1 in that bit; a hardware set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| save_n_in | input | 1 | Level sensed on the shared open-drain save line |
| save_n_oe | output | 1 | High to pull the save line low (save finished) |
| event_n | output | 1 | Active-low event notification to the host |
| reg_addr | input | ADDR_W | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| health_ok | input | 1 | Module health checks good |
| energy_ok | input | 1 | Backup energy store charged |
| host_iso | output | 1 | DRAM isolated from the host |
| pwr_req | output | 1 | Request to run from stored energy |
| pwr_ack | input | 1 | Power switch has moved to stored energy |
| cpy_start | output | 1 | Copy engine request, held until done |
| cpy_dir | output | 1 | 0 DRAM to flash, 1 flash to DRAM |
| cpy_done | input | 1 | Copy engine finished (one-cycle pulse) |
| cpy_fail | input | 1 | Qualifies cpy_done as a failure |
| off_req | output | 1 | Shut down all rails and clocks |
| pwr_ret | input | 1 | Main power has returned (pulse) |

## Verification
The assertions assume that cpy_done arrives only while a copy is requested, that pwr_ack follows pwr_req, and that pwr_ret is only pulsed in the shut-down state. They also assume that register writes are single-cycle strobes with a stable address. The bench keeps within these limits through a small responder. It acknowledges power only while pwr_req is high and returns one done pulse a fixed delay after cpy_start, with failure selected per scenario. Save requests come from a modelled open-drain line, so the module's own drive shows up on save_n_in just as it would on the board.

// File: rtl/nvb_pkg.sv
package nvb_pkg;
    localparam int unsigned DATA_W = 8;

    typedef enum logic [2:0] {
        PH_HOST    = 3'd0,
        PH_ISOLATE = 3'd1,
        PH_COPY    = 3'd2,
        PH_REPORT  = 3'd3,
        PH_OFF     = 3'd4,
        PH_RESTORE = 3'd5
    } phase_e;

    // packed so that busy lands in status bit 1 and terr in bit 5
    typedef struct packed {
        logic terr;
        logic rerr;
        logic serr;
        logic valid;
        logic busy;
    } flags_t;

    localparam int unsigned ADR_CTRL  = 0;
    localparam int unsigned ADR_STAT  = 1;
    localparam int unsigned ADR_PHASE = 2;
endpackage

// File: rtl/nvb_sync.sv
module nvb_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_n,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= 1'b1;
        else        chain_q[0] <= line_n;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[i] <= 1'b1;
                else        chain_q[i] <= chain_q[i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign fall = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/nvb_core.sv
module nvb_core
    import nvb_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   fall,
    input  logic   health_ok,
    input  logic   energy_ok,
    input  logic   arm_we,
    input  logic   arm_val,
    input  flags_t clr,
    input  logic   pwr_ack,
    input  logic   cpy_done,
    input  logic   cpy_fail,
    input  logic   pwr_ret,
    output phase_e phase,
    output logic   armed,
    output flags_t flags
);
    localparam int unsigned CW = $clog2(HOLD_CYC + 1);

    typedef struct packed {
        phase_e        ph;
        logic          armed;
        flags_t        fl;
        logic [CW-1:0] cnt;
    } st_t;

    st_t    st_d, st_q;
    flags_t set_v, keep_v;
    logic   healthy;

    always_comb begin
        st_d    = st_q;
        set_v   = '0;
        keep_v  = ~clr;
        healthy = health_ok & energy_ok;
        case (st_q.ph)
            PH_HOST: begin
                if (fall && st_q.armed) begin
                    st_d.ph      = PH_ISOLATE;
                    st_d.armed   = 1'b0;
                    set_v.busy   = 1'b1;
                    keep_v.valid = 1'b0;
                end else begin
                    if (fall) set_v.terr = 1'b1;
                    if (arm_we)        st_d.armed = arm_val & healthy;
                    else if (!healthy) st_d.armed = 1'b0;
                end
            end
            PH_ISOLATE: if (pwr_ack) st_d.ph = PH_COPY;
            PH_COPY: begin
                if (cpy_done) begin
                    st_d.ph  = PH_REPORT;
                    st_d.cnt = '0;
                    if (cpy_fail) set_v.serr  = 1'b1;
                    else          set_v.valid = 1'b1;
                end
            end
            PH_REPORT: begin
                if (st_q.cnt == CW'(HOLD_CYC - 1)) st_d.ph = PH_OFF;
                else st_d.cnt = st_q.cnt + 1'b1;
            end
            PH_OFF: begin
                if (pwr_ret) begin
                    if (st_q.fl.valid) st_d.ph = PH_RESTORE;
                    else begin
                        st_d.ph    = PH_HOST;
                        set_v.rerr = 1'b1;
                    end
                end
            end
            PH_RESTORE: begin
                if (cpy_done) begin
                    st_d.ph = PH_HOST;
                    if (cpy_fail) set_v.rerr = 1'b1;
                end
            end
            default: st_d.ph = PH_HOST;
        endcase
        st_d.fl = (st_q.fl & keep_v) | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ph: PH_HOST, armed: 1'b0, fl: '0, cnt: '0};
        else        st_q <= st_d;
    end

    assign phase = st_q.ph;
    assign armed = st_q.armed;
    assign flags = st_q.fl;

    // R2: arming only becomes visible after a cycle with good health and charge
    p_arm_needs_health_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.armed) |-> $past(health_ok && energy_ok));

    // R3: the copy phase is entered only on a power-switch acknowledge
    p_copy_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_COPY && $past(st_q.ph) == PH_ISOLATE) |-> $past(pwr_ack));

    // R9: an unarmed save edge keeps the host in charge and flags it
    p_unarmed_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_HOST && fall && !st_q.armed) |=> (st_q.ph == PH_HOST && st_q.fl.terr));

    // R10: a failed save never yields a valid image
    p_fail_no_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_COPY && cpy_done && cpy_fail) |=> (!st_q.fl.valid && st_q.fl.serr));

    // R12: error flags are sticky unless software clears them
    p_sticky_err_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fl.serr && !clr.serr) |=> st_q.fl.serr);

    // R4: the report phase starts only right after a copy completion
    p_report_after_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_REPORT && $past(st_q.ph) == PH_COPY) |-> $past(cpy_done));
endmodule

// File: rtl/nvm_backup_ctrl.sv
module nvm_backup_ctrl
    import nvb_pkg::*;
#(
    parameter int unsigned ADDR_W      = 2,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned HOLD_CYC    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              save_n_in,
    output logic              save_n_oe,
    output logic              event_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              health_ok,
    input  logic              energy_ok,
    output logic              host_iso,
    output logic              pwr_req,
    input  logic              pwr_ack,
    output logic              cpy_start,
    output logic              cpy_dir,
    input  logic              cpy_done,
    input  logic              cpy_fail,
    output logic              off_req,
    input  logic              pwr_ret
);
    logic   fall, armed, arm_we;
    phase_e phase;
    flags_t flags, clr;

    nvb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .line_n(save_n_in), .fall(fall)
    );

    assign arm_we = reg_we && (reg_addr == ADDR_W'(ADR_CTRL));
    assign clr    = (reg_we && (reg_addr == ADDR_W'(ADR_STAT))) ? flags_t'(reg_wdata[5:1]) : '0;

    nvb_core #(.HOLD_CYC(HOLD_CYC)) u_core (
        .clk(clk), .rst_n(rst_n), .fall(fall),
        .health_ok(health_ok), .energy_ok(energy_ok),
        .arm_we(arm_we), .arm_val(reg_wdata[0]), .clr(clr),
        .pwr_ack(pwr_ack), .cpy_done(cpy_done), .cpy_fail(cpy_fail),
        .pwr_ret(pwr_ret), .phase(phase), .armed(armed), .flags(flags)
    );

    assign host_iso  = (phase != PH_HOST);
    assign pwr_req   = (phase == PH_ISOLATE) || (phase == PH_COPY) || (phase == PH_REPORT);
    assign cpy_start = (phase == PH_COPY) || (phase == PH_RESTORE);
    assign cpy_dir   = (phase == PH_RESTORE);
    assign save_n_oe = (phase == PH_REPORT);
    assign off_req   = (phase == PH_OFF);
    assign event_n   = ~(flags.serr | flags.rerr | flags.terr);

    always_comb begin
        case (reg_addr)
            ADDR_W'(ADR_CTRL):  reg_rdata = {7'd0, armed};
            ADDR_W'(ADR_STAT):  reg_rdata = {health_ok, energy_ok, flags, armed};
            ADDR_W'(ADR_PHASE): reg_rdata = {5'd0, phase};
            default:            reg_rdata = '0;
        endcase
    end

    // R4: once the save line is released the module must already be shut down
    p_oe_then_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(save_n_oe) |-> off_req);

    // R5: the host regains the DRAM only at the end of a restore or an aborted one
    p_return_to_host_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_iso) |-> ($past(cpy_done) || $past(pwr_ret)));
endmodule

// File: tb/nvm_backup_ctrl_tb.sv
module nvm_backup_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 4;
    localparam int MAX_CYC    = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_n = 1'b1;
    logic       save_n_in, save_n_oe, event_n;
    logic [1:0] reg_addr = 2'd1;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       health_ok = 1'b0, energy_ok = 1'b0;
    logic       host_iso, pwr_req, pwr_ack = 1'b0;
    logic       cpy_start, cpy_dir, cpy_done = 1'b0, cpy_fail = 1'b0;
    logic       off_req, pwr_ret = 1'b0;
    logic       fail_mode = 1'b0;

    int checks = 0;
    int errors = 0;

    // open-drain line: either side can pull it low
    assign save_n_in = host_n & ~save_n_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    nvm_backup_ctrl #(.ADDR_W(2), .SYNC_STAGES(2), .HOLD_CYC(HOLD)) u_dut (
        .clk(clk), .rst_n(rst_n), .save_n_in(save_n_in), .save_n_oe(save_n_oe),
        .event_n(event_n), .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .health_ok(health_ok), .energy_ok(energy_ok),
        .host_iso(host_iso), .pwr_req(pwr_req), .pwr_ack(pwr_ack),
        .cpy_start(cpy_start), .cpy_dir(cpy_dir), .cpy_done(cpy_done),
        .cpy_fail(cpy_fail), .off_req(off_req), .pwr_ret(pwr_ret)
    );

    // ---------------- behavioural reference model ----------------
    int         m_ph, m_cnt;
    logic       m_armed;
    logic [7:0] m_fl;           // status bits 1..5 in their register positions
    logic       s1, s2, pv;

    always @(posedge clk or negedge rst_n) begin
        logic fall, healthy, acc;
        logic [7:0] setv, clrm;
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_armed = 0; m_fl = 8'd0;
            s1 = 1; s2 = 1; pv = 1;
        end else begin
            fall = pv && !s2;
            pv = s2; s2 = s1; s1 = save_n_in;
            healthy = health_ok && energy_ok;
            clrm = (reg_we && reg_addr == 2'd1) ? (reg_wdata & 8'h3E) : 8'd0;
            setv = 8'd0; acc = 0;
            case (m_ph)
                0: if (fall && m_armed) begin
                       m_ph = 1; m_armed = 0; setv[1] = 1; acc = 1;
                   end else begin
                       if (fall) setv[5] = 1;
                       if (reg_we && reg_addr == 2'd0) m_armed = reg_wdata[0] && healthy;
                       else if (!healthy) m_armed = 0;
                   end
                1: if (pwr_ack) m_ph = 2;
                2: if (cpy_done) begin
                       m_ph = 3; m_cnt = 0;
                       if (cpy_fail) setv[3] = 1; else setv[2] = 1;
                   end
                3: if (m_cnt == HOLD - 1) m_ph = 4; else m_cnt++;
                4: if (pwr_ret) begin
                       if (m_fl[2]) m_ph = 5;
                       else begin m_ph = 0; setv[4] = 1; end
                   end
                5: if (cpy_done) begin
                       m_ph = 0;
                       if (cpy_fail) setv[4] = 1;
                   end
                default: m_ph = 0;
            endcase
            m_fl = (m_fl & ~clrm & ~(acc ? 8'h04 : 8'h00)) | setv;
        end
    end

    function automatic logic [7:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0: return {7'd0, m_armed};
            2'd1: return {health_ok, energy_ok, m_fl[5:1], m_armed};
            2'd2: return 8'(m_ph);
            default: return 8'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the active edge
    initial begin
        forever begin
            @(negedge clk); #1;
            if (rst_n) begin
                chk("R3 outputs {iso,pwr,start,dir}", {host_iso, pwr_req, cpy_start, cpy_dir},
                    {m_ph != 0, m_ph >= 1 && m_ph <= 3, m_ph == 2 || m_ph == 5, m_ph == 5});
                chk("R4 off_req", off_req, m_ph == 4);
                chk("R6 save_n_oe", save_n_oe, m_ph == 3);
                chk("R7 event_n", event_n, !(m_fl[3] | m_fl[4] | m_fl[5]));
                chk("R8 reg_rdata", reg_rdata, exp_rd(reg_addr));
            end
        end
    end

    // power switch and copy engine responder
    initial begin
        int cc = 0;
        forever begin
            @(negedge clk);
            pwr_ack = pwr_req;
            if (cpy_done) begin
                cpy_done = 0; cpy_fail = 0; cc = 0;
            end else if (cpy_start) begin
                cc++;
                if (cc == 3) begin cpy_done = 1; cpy_fail = fail_mode; end
            end
        end
    end

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1;
        @(negedge clk);
        reg_we = 0; reg_addr = 2'd1;
    endtask

    task automatic read_chk(input string tag, input logic [1:0] a, input logic [7:0] exp);
        @(negedge clk);
        reg_addr = a; #1;
        chk(tag, reg_rdata, exp);
        reg_addr = 2'd1;
    endtask

    task automatic pull_save;
        @(negedge clk); host_n = 0;
        repeat (3) @(negedge clk);
        host_n = 1;
    endtask

    task automatic wait_off(output int oe_cycles);
        oe_cycles = 0;
        for (int i = 0; i < 200 && !off_req; i++) begin
            @(negedge clk); #2;
            if (save_n_oe) oe_cycles++;
        end
    endtask

    task automatic power_back;
        @(negedge clk); pwr_ret = 1;
        @(negedge clk); pwr_ret = 0;
        for (int i = 0; i < 50 && host_iso; i++) @(negedge clk);
        #2;
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        // R1 reset state
        chk("R1 host_iso", host_iso, 0);
        chk("R1 event_n", event_n, 1);
        chk("R1 requests", {pwr_req, cpy_start, save_n_oe, off_req}, 0);
        read_chk("R1 status", 2'd1, 8'h00);

        // R2 arming refused without charge
        health_ok = 1;
        reg_write(2'd0, 8'h01);
        read_chk("R2 refused", 2'd0, 8'h00);

        // R9 unarmed trigger ignored but flagged
        pull_save;
        repeat (4) @(negedge clk); #1;
        chk("R9 still host", host_iso, 0);
        read_chk("R9 phase", 2'd2, 8'h00);
        read_chk("R9 status", 2'd1, 8'hA0);
        chk("R7 event low", event_n, 0);
        reg_write(2'd1, 8'h20);
        #1 chk("R7 event high", event_n, 1);
        read_chk("R12 w1c", 2'd1, 8'h80);

        // R2 arm, lose charge, re-arm
        energy_ok = 1;
        reg_write(2'd0, 8'h01);
        read_chk("R2 armed", 2'd0, 8'h01);
        @(negedge clk); energy_ok = 0;
        @(negedge clk); energy_ok = 1;
        read_chk("R2 disarm", 2'd0, 8'h00);
        reg_write(2'd0, 8'h01);
        read_chk("R8 addr3", 2'd3, 8'h00);

        // R3/R4/R6 good save
        pull_save;
        wait_off(n);
        chk("R6 oe cycles", n, HOLD);
        chk("R4 off", off_req, 1);
        chk("R4 energy released", pwr_req, 0);
        read_chk("R4 status", 2'd1, 8'hC6);
        read_chk("R8 phase off", 2'd2, 8'h04);
        power_back;
        chk("R5 host back", host_iso, 0);
        read_chk("R5 disarmed", 2'd0, 8'h00);
        reg_write(2'd1, 8'h02);
        read_chk("R12 keep valid", 2'd1, 8'hC4);

        // R10 failed save, then R11 power return without image
        reg_write(2'd0, 8'h01);
        fail_mode = 1;
        pull_save;
        wait_off(n);
        chk("R10 oe cycles", n, HOLD);
        read_chk("R10 status", 2'd1, 8'hCA);
        chk("R7 event on serr", event_n, 0);
        power_back;
        chk("R11 host back", host_iso, 0);
        read_chk("R11 status", 2'd1, 8'hDA);
        reg_write(2'd1, 8'h3E);
        read_chk("R12 clear all", 2'd1, 8'hC0);

        // R11 restore failure
        fail_mode = 0;
        reg_write(2'd0, 8'h01);
        pull_save;
        wait_off(n);
        fail_mode = 1;
        power_back;
        read_chk("R11 restore fail", 2'd1, 8'hD6);
        fail_mode = 0;

        repeat (5) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule